// File: doc/BRIEF.md
# Synchronous FIFO with Pointer Marks and Byte Realignment

This block is a synchronous word FIFO whose read and write pointers count in bytes. Each pointer has a companion mark register. A mark strobe copies the live pointer into its mark. A restore strobe loads the live pointer back from its mark. Restoring the read side lets a consumer read a packet again after an error. Restoring the write side lets a producer throw away a partly written packet and write over it.

Word reads and writes move a pointer by one word. Two separate strobes each move one pointer by a single byte. They are used to bring a pointer back onto a word boundary after an odd number of bytes has crossed a byte-wide port. None of the pointer strobes takes an operand. The block reports empty and full and shows the word at the read position on its output without waiting for a read.

Top module: `fifo_mark_top`

## Requirements
- R1: After reset, both pointers and both marks are 0, `empty` is 1 and `full` is 0. An immediate restore therefore leaves both pointers at 0.
- R2: An accepted write stores `wr_data` in the word that holds byte `wr_ptr`. `rd_data` always shows the word that holds byte `rd_ptr`. Each accepted word access moves its pointer by DATA_W/8 bytes, so data comes out in write order.
- R3: `full` is 1 exactly when the pointers differ only in their top (wrap) bit, that is when `wr_ptr - rd_ptr` equals DEPTH*DATA_W/8. A write while full is ignored: `wr_ptr` and the stored data do not change.
- R4: `empty` is 1 exactly when `rd_ptr == wr_ptr`. A read while empty is ignored and `rd_ptr` does not move.
- R5: `mark_rd` copies the current `rd_ptr` into the read mark. `restore_rd` loads `rd_ptr` from the read mark, so the reads that follow return data from the marked position again.
- R6: `mark_wr` copies the current `wr_ptr` into the write mark. `restore_wr` loads `wr_ptr` from the write mark, so data written after the mark is dropped and the next writes overwrite it.
- R7: When a restore and a word access on the same pointer fall in the same cycle, the restore wins. The pointer takes the mark value, and the write (or read) is not carried out.
- R8: `bump_rd` advances `rd_ptr` by one byte and `bump_wr` advances `wr_ptr` by one byte. A word access at a pointer that is not on a word boundary uses the word that contains that byte (byte offset = low log2(DATA_W/8) bits).
- R9: `bump_rd` is ignored while empty and `bump_wr` is ignored while full.
- R10: A bump together with an accepted word access on the same pointer moves that pointer by DATA_W/8 + 1 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Word write request |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Word read request (consumes the word on rd_data) |
| rd_data | output | DATA_W | Word at the read position |
| mark_rd | input | 1 | Copy read pointer into read mark |
| mark_wr | input | 1 | Copy write pointer into write mark |
| restore_rd | input | 1 | Load read pointer from read mark |
| restore_wr | input | 1 | Load write pointer from write mark |
| bump_rd | input | 1 | Advance read pointer by one byte |
| bump_wr | input | 1 | Advance write pointer by one byte |
| empty | output | 1 | Pointers equal |
| full | output | 1 | Pointers differ only in the wrap bit |
| rd_ptr | output | log2(DEPTH*DATA_W/8)+1 | Read byte pointer including wrap bit |
| wr_ptr | output | log2(DEPTH*DATA_W/8)+1 | Write byte pointer including wrap bit |

## Verification
The bench builds the block with DATA_W=32 and DEPTH=4. That gives four bytes per word and 5-bit pointers. At this size the FIFO fills after four writes, so the full flag and the ignored write at full are quick to reach. Both pointers also wrap past zero during the marked-reread sequence. Four bytes per word allow byte offsets of 1 to 3, so the bench can place words at misaligned write positions and then realign the read pointer with three single-byte steps.

// File: rtl/fifo_mark_pkg.sv
package fifo_mark_pkg;

  // Per-pointer control, already qualified by the top level
  typedef struct packed {
    logic step;     // accepted word access
    logic bump;     // accepted single-byte advance
    logic mark;     // capture pointer into mark
    logic restore;  // load pointer from mark
  } ptr_ctl_t;

endpackage

// File: rtl/fifo_mark_rst_sync.sv
module fifo_mark_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fifo_mark_ptr.sv
module fifo_mark_ptr
  import fifo_mark_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ptr_ctl_t         ctl,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] mark_q
);

  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);
  localparam logic [PTR_W-1:0] ONE_V  = PTR_W'(1);

  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] mark_d;
  logic             ptr_en;
  logic             mark_en;

  // Next-state: restore has priority over any movement
  always_comb begin
    ptr_d = ptr_q;
    if (ctl.restore) begin
      ptr_d = mark_q;
    end else begin
      if (ctl.step) ptr_d = ptr_d + STEP_V;
      if (ctl.bump) ptr_d = ptr_d + ONE_V;
    end
    ptr_en  = ctl.restore | ctl.step | ctl.bump;
    mark_d  = ptr_q;
    mark_en = ctl.mark;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mark_q <= '0;
    end else begin
      if (ptr_en)  ptr_q  <= ptr_d;
      if (mark_en) mark_q <= mark_d;
    end
  end

endmodule

// File: rtl/fifo_mark_store.sv
module fifo_mark_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              word_en;

    assign word_en = we && (waddr == AW'(g));

    always_ff @(posedge clk) begin
      if (word_en) word_q <= wdata;
    end

    assign words[g] = word_q;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/fifo_mark_top.sv
module fifo_mark_top
  import fifo_mark_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        wr_en,
  input  logic [DATA_W-1:0]                           wr_data,
  input  logic                                        rd_en,
  output logic [DATA_W-1:0]                           rd_data,
  input  logic                                        mark_rd,
  input  logic                                        mark_wr,
  input  logic                                        restore_rd,
  input  logic                                        restore_wr,
  input  logic                                        bump_rd,
  input  logic                                        bump_wr,
  output logic                                        empty,
  output logic                                        full,
  output logic [$clog2(DEPTH)+$clog2(DATA_W/8):0]     rd_ptr,
  output logic [$clog2(DEPTH)+$clog2(DATA_W/8):0]     wr_ptr
);

  localparam int BPW   = DATA_W / 8;
  localparam int BOFF  = $clog2(BPW);
  localparam int WAW   = $clog2(DEPTH);
  localparam int PTR_W = WAW + BOFF + 1;
  localparam logic [PTR_W-1:0] WRAP_V = {1'b1, {(PTR_W-1){1'b0}}};

  logic             rst_core_n;
  ptr_ctl_t         rd_ctl;
  ptr_ctl_t         wr_ctl;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_mark_q;
  logic [PTR_W-1:0] wr_mark_q;
  logic             is_empty;
  logic             is_full;

  fifo_mark_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // Flags from pointer comparison
  always_comb begin
    is_empty = (rd_ptr_q == wr_ptr_q);
    is_full  = ((rd_ptr_q ^ wr_ptr_q) == WRAP_V);
  end

  // Qualify requests: restore wins, empty/full block movement
  always_comb begin
    rd_ctl.restore = restore_rd;
    rd_ctl.mark    = mark_rd;
    rd_ctl.step    = rd_en   & ~is_empty & ~restore_rd;
    rd_ctl.bump    = bump_rd & ~is_empty & ~restore_rd;
    wr_ctl.restore = restore_wr;
    wr_ctl.mark    = mark_wr;
    wr_ctl.step    = wr_en   & ~is_full  & ~restore_wr;
    wr_ctl.bump    = bump_wr & ~is_full  & ~restore_wr;
  end

  fifo_mark_ptr #(.PTR_W(PTR_W), .STEP(BPW)) u_rd_ptr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ctl    (rd_ctl),
    .ptr_q  (rd_ptr_q),
    .mark_q (rd_mark_q)
  );

  fifo_mark_ptr #(.PTR_W(PTR_W), .STEP(BPW)) u_wr_ptr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .ctl    (wr_ctl),
    .ptr_q  (wr_ptr_q),
    .mark_q (wr_mark_q)
  );

  fifo_mark_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_ctl.step),
    .waddr (wr_ptr_q[PTR_W-2:BOFF]),
    .wdata (wr_data),
    .raddr (rd_ptr_q[PTR_W-2:BOFF]),
    .rdata (rd_data)
  );

  assign empty  = is_empty;
  assign full   = is_full;
  assign rd_ptr = rd_ptr_q;
  assign wr_ptr = wr_ptr_q;

endmodule

// File: rtl/fifo_mark_chk.sv
module fifo_mark_chk #(
  parameter int PTR_W = 6,
  parameter int BPW   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             wr_en,
  input logic             mark_rd,
  input logic             mark_wr,
  input logic             restore_rd,
  input logic             restore_wr,
  input logic             bump_rd,
  input logic             bump_wr,
  input logic             empty,
  input logic             full,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_mark,
  input logic [PTR_W-1:0] wr_mark
);

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  p_hold_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !restore_rd) |=> $stable(rd_ptr));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !restore_wr) |=> $stable(wr_ptr));

  p_rd_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty && !restore_rd && !bump_rd) |=> (rd_ptr == PTR_W'($past(rd_ptr) + PTR_W'(BPW))));

  p_mark_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mark_rd |=> (rd_mark == $past(rd_ptr)));

  p_mark_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_wr |=> (wr_mark == $past(wr_ptr)));

  p_restore_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_rd |=> (rd_ptr == $past(rd_mark)));

  p_restore_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_wr |=> (wr_ptr == $past(wr_mark)));

  p_bump_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_rd && !rd_en && !empty && !restore_rd) |=> (rd_ptr == PTR_W'($past(rd_ptr) + PTR_W'(1))));

  p_bump_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bump_wr && wr_en && !full && !restore_wr) |=> (wr_ptr == PTR_W'($past(wr_ptr) + PTR_W'(BPW + 1))));

endmodule

bind fifo_mark_top fifo_mark_chk #(.PTR_W(PTR_W), .BPW(BPW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .mark_rd    (mark_rd),
  .mark_wr    (mark_wr),
  .restore_rd (restore_rd),
  .restore_wr (restore_wr),
  .bump_rd    (bump_rd),
  .bump_wr    (bump_wr),
  .empty      (empty),
  .full       (full),
  .rd_ptr     (rd_ptr_q),
  .wr_ptr     (wr_ptr_q),
  .rd_mark    (rd_mark_q),
  .wr_mark    (wr_mark_q)
);

// File: tb/fifo_mark_top_tb_top.sv
module fifo_mark_top_tb_top;

  localparam int DW    = 32;
  localparam int DEPTH = 4;
  localparam int PW    = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en, mark_rd, mark_wr, restore_rd, restore_wr, bump_rd, bump_wr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          empty, full;
  logic [PW-1:0] rd_ptr, wr_ptr;

  int checks   = 0;
  int failures = 0;
  logic mon_on = 1'b0;
  logic [DW-1:0] exp_q [$];

  always #4 clk = ~clk;

  fifo_mark_top #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .mark_rd(mark_rd), .mark_wr(mark_wr), .restore_rd(restore_rd),
    .restore_wr(restore_wr), .bump_rd(bump_rd), .bump_wr(bump_wr), .empty(empty),
    .full(full), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected words as the design consumes them
  always @(negedge clk) begin
    if (mon_on && rd_en && !empty) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R2 unexpected read actual=%0h expected=none", rd_data);
      end else begin
        chk("R2 stream order", rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic cyc(input logic we, input logic [DW-1:0] d, input logic re,
                     input logic mr, input logic mw, input logic rr, input logic rw,
                     input logic br, input logic bw);
    @(posedge clk);
    #2;
    wr_en = we; wr_data = d; rd_en = re; mark_rd = mr; mark_wr = mw;
    restore_rd = rr; restore_wr = rw; bump_rd = br; bump_wr = bw;
  endtask

  task automatic idle();   cyc(0, '0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input logic [DW-1:0] d); cyc(1, d, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd();     cyc(0, '0, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic push(input logic [DW-1:0] d);
    exp_q.push_back(d);
    wr(d);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    wr_en = 0; wr_data = '0; rd_en = 0; mark_rd = 0; mark_wr = 0;
    restore_rd = 0; restore_wr = 0; bump_rd = 0; bump_wr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) idle();

    // R1: reset state
    chk("R1 empty", DW'(empty), 1);
    chk("R1 full", DW'(full), 0);
    chk("R1 rd_ptr", DW'(rd_ptr), 0);
    chk("R1 wr_ptr", DW'(wr_ptr), 0);
    cyc(0, '0, 0, 0, 0, 1, 1, 0, 0); idle();
    chk("R1 marks zero rd", DW'(rd_ptr), 0);
    chk("R1 marks zero wr", DW'(wr_ptr), 0);

    // R2: streaming through the scoreboard
    mon_on = 1'b1;
    push(32'h1111_0001); push(32'h2222_0002); push(32'h3333_0003);
    rd(); rd(); rd(); idle();
    chk("R2 rd_ptr after 3", DW'(rd_ptr), 12);
    chk("R2 empty after drain", DW'(empty), 1);

    // R3: fill to full, extra write ignored
    push(32'hA0A0_0010); push(32'hA0A0_0011); push(32'hA0A0_0012); push(32'hA0A0_0013);
    idle();
    chk("R3 full", DW'(full), 1);
    chk("R3 wr_ptr at full", DW'(wr_ptr), 28);
    wr(32'hDEAD_BEEF); idle();
    chk("R3 write at full ignored", DW'(wr_ptr), 28);
    rd(); rd(); rd(); rd(); idle();
    chk("R3 drained empty", DW'(empty), 1);
    chk("R3 drained queue", DW'(exp_q.size()), 0);
    mon_on = 1'b0;

    // R4: read while empty ignored
    rd(); idle();
    chk("R4 rd_ptr held", DW'(rd_ptr), 28);
    chk("R4 still empty", DW'(empty), 1);

    // R5: mark read, read two, restore, reread
    wr(32'h0000_00A1); wr(32'h0000_00B2); wr(32'h0000_00C3);
    cyc(0, '0, 0, 1, 0, 0, 0, 0, 0);
    rd(); rd(); idle();
    chk("R5 before restore", rd_data, 32'h0000_00C3);
    cyc(0, '0, 0, 0, 0, 1, 0, 0, 0); idle();
    chk("R5 rd_ptr restored", DW'(rd_ptr), 28);
    chk("R5 reread first", rd_data, 32'h0000_00A1);
    rd(); idle(); chk("R5 reread second", rd_data, 32'h0000_00B2);
    rd(); idle(); chk("R5 reread third", rd_data, 32'h0000_00C3);
    rd(); idle(); chk("R5 empty after reread", DW'(empty), 1);

    // R6: mark write, write two, restore, overwrite
    cyc(0, '0, 0, 0, 1, 0, 0, 0, 0);
    wr(32'h0000_0E01); wr(32'h0000_0E02);
    cyc(0, '0, 0, 0, 0, 0, 1, 0, 0); idle();
    chk("R6 wr_ptr restored", DW'(wr_ptr), 8);
    chk("R6 discarded empty", DW'(empty), 1);
    wr(32'h0000_0F0F); idle();
    chk("R6 overwritten data", rd_data, 32'h0000_0F0F);
    chk("R6 wr_ptr after", DW'(wr_ptr), 12);

    // R7: restore beats simultaneous access
    cyc(0, '0, 0, 1, 1, 0, 0, 0, 0);
    cyc(1, 32'h0BAD_0BAD, 1, 0, 0, 1, 1, 0, 0); idle();
    chk("R7 rd_ptr restore wins", DW'(rd_ptr), 8);
    chk("R7 wr_ptr restore wins", DW'(wr_ptr), 12);
    chk("R7 data kept", rd_data, 32'h0000_0F0F);
    wr(32'h0000_0C0C); rd(); idle();
    chk("R7 write not stored", rd_data, 32'h0000_0C0C);
    rd(); idle();

    // R8: byte bumps and misaligned writes
    wr(32'h0000_AAAA);
    cyc(0, '0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, '0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, '0, 0, 0, 0, 0, 0, 0, 1);
    wr(32'h0000_BBBB); idle();
    chk("R8 wr_ptr misaligned", DW'(wr_ptr), 27);
    chk("R8 first word", rd_data, 32'h0000_AAAA);
    rd(); idle();
    chk("R8 misaligned write word", rd_data, 32'h0000_BBBB);
    rd(); idle();
    chk("R8 not empty before realign", DW'(empty), 0);
    cyc(0, '0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, '0, 0, 0, 0, 0, 0, 1, 0);
    cyc(0, '0, 0, 0, 0, 0, 0, 1, 0); idle();
    chk("R8 rd_ptr realigned", DW'(rd_ptr), 27);
    chk("R8 empty after realign", DW'(empty), 1);

    // R9: bumps ignored at empty / full
    cyc(0, '0, 0, 0, 0, 0, 0, 1, 0); idle();
    chk("R9 bump_rd at empty", DW'(rd_ptr), 27);
    wr(32'h1); wr(32'h2); wr(32'h3); wr(32'h4); idle();
    chk("R9 full", DW'(full), 1);
    cyc(0, '0, 0, 0, 0, 0, 0, 0, 1); idle();
    chk("R9 bump_wr at full", DW'(wr_ptr), 11);

    // R10: bump combined with access
    cyc(0, '0, 1, 0, 0, 0, 0, 1, 0); idle();
    chk("R10 rd_ptr word+byte", DW'(rd_ptr), 0);
    chk("R10 not full", DW'(full), 0);
    cyc(1, 32'h5, 0, 0, 0, 0, 0, 0, 1); idle();
    chk("R10 wr_ptr word+byte", DW'(wr_ptr), 16);
    chk("R10 full again", DW'(full), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule